// File: doc/BRIEF.md
# Dual-Tone Phase-Accumulator Sine Generator

This block produces the sample stream for one converter channel as the sum of two sine tones. Each tone has its own phase accumulator, advanced by a programmable increment, started from a programmable phase offset, and weighted by a signed gain. The top bits of each accumulator address a sine table that is computed when the design is elaborated. The two weighted tones are added and clamped to the signed 16-bit range.

The accumulator width `PHASE_W` can be set from 16 to 32 bits, and software can read it back. Increments and phase offsets wider than 16 bits are split across two registers. A base register holds the low 16 bits. An extension register holds the remaining high bits. Settings are written through a simple write port and read through a combinational read port.

Samples leave on a valid/ready stream. Once `smp_valid` is high, the sample is held unchanged until `smp_ready` is seen high at a clock edge. While the sample waits, both accumulators hold their values, so back-pressure never drops or skips a sample. Raising `gen_enable`, or pulsing `reapply` while enabled, loads the phase offsets into the accumulators. On that load cycle `smp_valid` is cleared. The first sample, taken at the loaded phase, appears one cycle later. Setting `GEN_EN` to 0 removes the generator datapath.

Top module: `dds_dual_tone`

## Requirements
- R1: After reset, every setting reads back as zero and `smp_valid` is low.
- R2: Address 0 returns the accumulator width `PHASE_W` in bits [21:16] and the tone-A gain in bits [15:0]. The width field is read-only, and writes do not change it.
- R3: Suppose `gen_enable` rises, or `reapply` is high while `gen_enable` is high. Each accumulator then loads its phase offset and `smp_valid` goes low. On the next cycle the first sample is presented, computed from the loaded phases.
- R4: Sample number k of a tone uses phase (offset + k·increment) mod 2^PHASE_W. The sine table is indexed by the top `LUT_BITS` bits of that phase. Table entry i is round(32767·sin(2πi/2^LUT_BITS)).
- R5: For `PHASE_W` > 16, the extension register supplies the upper PHASE_W−16 bits and the base register supplies the lower 16. The increment occupies bits [15:0] of each register and the offset occupies bits [31:16]. Extension bits above PHASE_W−17 read as zero.
- R6: For `PHASE_W` = 16, the extension registers read as zero and writes to them have no effect on the output.
- R7: Each gain is a signed 1.1.14 value (0x4000 = +1.0, 0xC000 = −1.0). A tone's contribution is (sine · gain) arithmetically shifted right by 14.
- R8: The output is the sum of the two tone contributions.
- R9: A sum above 32767 is output as 32767, and a sum below −32768 is output as −32768. It never wraps.
- R10: While `smp_valid` is high and `smp_ready` is low, `smp_valid` stays high and `smp_data` stays unchanged. The next accepted sample is the next one in the sequence.
- R11: One cycle after `gen_enable` is low, `smp_valid` is low.
- R12: With `GEN_EN` = 0, `smp_valid` stays low and `smp_data` stays zero.

Register addresses: 0 tone-A gain, 1 tone-A offset/increment base, 2 tone-B gain, 3 tone-B offset/increment base, 4 tone-A extension, 5 tone-B extension.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_enable | input | 1 | Run the generator; a rising level loads phase offsets |
| reapply | input | 1 | Reload phase offsets while enabled |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 3 | Register write address |
| cfg_wr_data | input | 32 | Register write data |
| cfg_rd_addr | input | 3 | Register read address |
| cfg_rd_data | output | 32 | Register read data (combinational) |
| smp_valid | output | 1 | Output sample valid |
| smp_ready | input | 1 | Downstream accepts the sample |
| smp_data | output | 16 | Signed output sample |

## Verification
The bench drives a 24-bit instance and a 16-bit instance side by side. The 16-bit instance shows whether extension bits leak into a narrow accumulator; if they did, its frequency or phase would drift from the expected sequence. A design that splits base and extension wrongly would step through the table at the wrong rate. Full-scale gains on both tones at the positive and negative peaks expose a sum that wraps instead of clamping, which flips the sign of the output. A stalled-ready pattern and a mid-stream reload expose an accumulator that advances while a sample waits, or that does not restart from the offset; either shows up as a skipped or misaligned sample.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int SMP_W     = 16;
  localparam int SCALE_W   = 16;
  localparam int FRAC_BITS = 14;
  localparam int TERM_W    = SMP_W + 2;
  localparam int ADDR_W    = 3;
  localparam int NUM_TONES = 2;

  typedef logic signed [SMP_W-1:0]  smp_t;
  typedef logic signed [TERM_W-1:0] term_t;

  typedef enum logic [ADDR_W-1:0] {
    SEL_A_CTL = 3'd0,
    SEL_A_PH  = 3'd1,
    SEL_B_CTL = 3'd2,
    SEL_B_PH  = 3'd3,
    SEL_A_EXT = 3'd4,
    SEL_B_EXT = 3'd5
  } cfg_sel_e;

  // pi in Q28
  localparam longint PI_Q28 = 64'sd843314857;

  // One full-wave entry, amplitude 32767, via folded Taylor series in Q28.
  function automatic smp_t sine_point(input int idx, input int lut_bits);
    longint n, half, qtr, j, x, term, acc, amp;
    bit neg;
    n    = longint'(1) << lut_bits;
    half = n / 2;
    qtr  = n / 4;
    neg  = (longint'(idx) >= half);
    j    = longint'(idx) % half;
    if (j > qtr) j = half - j;
    x    = (j * PI_Q28) / half;
    acc  = x;
    term = x;
    for (int k = 1; k < 8; k++) begin
      term = -((term * x) >>> 28);
      term = (term * x) >>> 28;
      term = term / longint'((2 * k) * (2 * k + 1));
      acc  = acc + term;
    end
    amp = (acc * 64'sd32767 + (longint'(1) << 27)) >>> 28;
    if (amp > 64'sd32767) amp = 64'sd32767;
    if (amp < 64'sd0) amp = 64'sd0;
    return smp_t'(neg ? -amp : amp);
  endfunction
endpackage

// File: rtl/dds_cfg_regs.sv
module dds_cfg_regs import dds_pkg::*; #(
  parameter int PHASE_W = 24
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [ADDR_W-1:0]                     wr_addr,
  input  logic [31:0]                           wr_data,
  input  logic [ADDR_W-1:0]                     rd_addr,
  output logic [31:0]                           rd_data,
  output logic [NUM_TONES-1:0][SCALE_W-1:0]     scale,
  output logic [NUM_TONES-1:0][PHASE_W-1:0]     incr,
  output logic [NUM_TONES-1:0][PHASE_W-1:0]     init
);
  localparam bit HAS_EXT = (PHASE_W > 16);
  localparam int EXT_W   = HAS_EXT ? PHASE_W - 16 : 1;
  localparam logic [5:0] WIDTH_FIELD = 6'(PHASE_W);

  logic [NUM_TONES-1:0][15:0] incr_lo_v, init_lo_v;
  logic [NUM_TONES-1:0][31:0] ext_rd;

  for (genvar t = 0; t < NUM_TONES; t++) begin : g_tone
    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(2 * t);
    localparam logic [ADDR_W-1:0] PH_A  = ADDR_W'(2 * t + 1);
    localparam logic [ADDR_W-1:0] EXT_A = ADDR_W'(4 + t);

    logic [15:0] scale_r, incr_lo_r, init_lo_r;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        scale_r   <= '0;
        incr_lo_r <= '0;
        init_lo_r <= '0;
      end else if (wr_en) begin
        if (wr_addr == CTL_A) scale_r <= wr_data[15:0];
        if (wr_addr == PH_A) begin
          init_lo_r <= wr_data[31:16];
          incr_lo_r <= wr_data[15:0];
        end
      end
    end

    assign scale[t]     = scale_r;
    assign incr_lo_v[t] = incr_lo_r;
    assign init_lo_v[t] = init_lo_r;

    if (HAS_EXT) begin : g_ext
      logic [EXT_W-1:0] incr_hi_r, init_hi_r;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          incr_hi_r <= '0;
          init_hi_r <= '0;
        end else if (wr_en && wr_addr == EXT_A) begin
          init_hi_r <= wr_data[16 +: EXT_W];
          incr_hi_r <= wr_data[0 +: EXT_W];
        end
      end
      assign incr[t]   = {incr_hi_r, incr_lo_r};
      assign init[t]   = {init_hi_r, init_lo_r};
      assign ext_rd[t] = {16'(init_hi_r), 16'(incr_hi_r)};
    end else begin : g_noext
      assign incr[t]   = incr_lo_r;
      assign init[t]   = init_lo_r;
      assign ext_rd[t] = '0;
    end
  end

  always_comb begin
    case (cfg_sel_e'(rd_addr))
      SEL_A_CTL: rd_data = {10'd0, WIDTH_FIELD, scale[0]};
      SEL_A_PH:  rd_data = {init_lo_v[0], incr_lo_v[0]};
      SEL_B_CTL: rd_data = {16'd0, scale[1]};
      SEL_B_PH:  rd_data = {init_lo_v[1], incr_lo_v[1]};
      SEL_A_EXT: rd_data = ext_rd[0];
      SEL_B_EXT: rd_data = ext_rd[1];
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int PHASE_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               advance,
  input  logic [PHASE_W-1:0] init_val,
  input  logic [PHASE_W-1:0] incr_val,
  output logic [PHASE_W-1:0] phase
);
  always_ff @(posedge clk) begin
    if (!rst_n)       phase <= '0;
    else if (load)    phase <= init_val;
    else if (advance) phase <= phase + incr_val;
  end

  // R3: offset lands in the accumulator on load
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> phase == $past(init_val));

  // R4: modular step per produced sample
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> phase == PHASE_W'($past(phase) + $past(incr_val)));
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom import dds_pkg::*; #(
  parameter int LUT_BITS = 8
) (
  input  logic [LUT_BITS-1:0] idx,
  output smp_t                value
);
  localparam int DEPTH = 1 << LUT_BITS;

  smp_t table_w [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    localparam smp_t ENTRY = sine_point(gi, LUT_BITS);
    assign table_w[gi] = ENTRY;
  end

  assign value = table_w[idx];
endmodule

// File: rtl/dds_tone_scale.sv
module dds_tone_scale import dds_pkg::*; (
  input  smp_t                      wave,
  input  logic signed [SCALE_W-1:0] gain,
  output term_t                     term
);
  logic signed [SMP_W+SCALE_W-1:0] prod;

  assign prod = wave * gain;
  assign term = term_t'(prod >>> FRAC_BITS);
endmodule

// File: rtl/dds_mix_sat.sv
module dds_mix_sat import dds_pkg::*; (
  input  term_t a,
  input  term_t b,
  output smp_t  y
);
  localparam logic signed [TERM_W:0] SUM_HI = (TERM_W+1)'(32767);
  localparam logic signed [TERM_W:0] SUM_LO = (TERM_W+1)'(-32768);

  logic signed [TERM_W:0] sum;

  assign sum = a + b;

  always_comb begin
    if (sum > SUM_HI)      y = smp_t'(SUM_HI);
    else if (sum < SUM_LO) y = smp_t'(SUM_LO);
    else                   y = smp_t'(sum);
  end
endmodule

// File: rtl/dds_dual_tone.sv
module dds_dual_tone import dds_pkg::*; #(
  parameter int PHASE_W  = 24,
  parameter int LUT_BITS = 8,
  parameter bit GEN_EN   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_enable,
  input  logic              reapply,
  input  logic              cfg_wr_en,
  input  logic [ADDR_W-1:0] cfg_wr_addr,
  input  logic [31:0]       cfg_wr_data,
  input  logic [ADDR_W-1:0] cfg_rd_addr,
  output logic [31:0]       cfg_rd_data,
  output logic              smp_valid,
  input  logic              smp_ready,
  output logic [SMP_W-1:0]  smp_data
);
  logic [NUM_TONES-1:0][SCALE_W-1:0] scale;
  logic [NUM_TONES-1:0][PHASE_W-1:0] incr, init;

  dds_cfg_regs #(.PHASE_W(PHASE_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_addr (cfg_wr_addr),
    .wr_data (cfg_wr_data),
    .rd_addr (cfg_rd_addr),
    .rd_data (cfg_rd_data),
    .scale   (scale),
    .incr    (incr),
    .init    (init)
  );

  if (GEN_EN) begin : g_gen
    logic en_q, load, advance, valid_q;
    smp_t data_q, mixed;
    logic [NUM_TONES-1:0][PHASE_W-1:0] phase;
    term_t terms [NUM_TONES];

    assign load    = gen_enable & (~en_q | reapply);
    assign advance = gen_enable & ~load & (~valid_q | smp_ready);

    for (genvar t = 0; t < NUM_TONES; t++) begin : g_tone
      smp_t wave;

      dds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .advance  (advance),
        .init_val (init[t]),
        .incr_val (incr[t]),
        .phase    (phase[t])
      );

      dds_sine_rom #(.LUT_BITS(LUT_BITS)) u_rom (
        .idx   (phase[t][PHASE_W-1 -: LUT_BITS]),
        .value (wave)
      );

      dds_tone_scale u_scl (
        .wave (wave),
        .gain (scale[t]),
        .term (terms[t])
      );
    end

    dds_mix_sat u_mix (
      .a (terms[0]),
      .b (terms[1]),
      .y (mixed)
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q    <= 1'b0;
        valid_q <= 1'b0;
        data_q  <= '0;
      end else begin
        en_q <= gen_enable;
        if (!gen_enable || load) begin
          valid_q <= 1'b0;
        end else if (advance) begin
          valid_q <= 1'b1;
          data_q  <= mixed;
        end
      end
    end

    assign smp_valid = valid_q;
    assign smp_data  = data_q;

    // R10: a waiting sample is held
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && !smp_ready && gen_enable && !load) |=> (smp_valid && $stable(smp_data)));

    // R11: disabling drops the stream
    a_r11_off: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_enable |=> !smp_valid);

    // R3: load cycle presents no sample
    a_r3_gap: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !smp_valid);
  end else begin : g_off
    assign smp_valid = 1'b0;
    assign smp_data  = '0;
  end
endmodule

// File: tb/dds_dual_tone_tb.sv
module dds_dual_tone_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LUT = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        gen_enable = 0, reapply = 0, wr_en = 0, ready = 1;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd24, rd16, rdoff;
  logic        v24, v16, voff;
  logic [15:0] d24, d16, doff;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [15:0] m_scale [2], m_incr_lo [2], m_init_lo [2], m_incr_hi [2], m_init_hi [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_dual_tone #(.PHASE_W(24), .LUT_BITS(LUT)) u_dut (
    .clk(clk), .rst_n(rst_n), .gen_enable(gen_enable), .reapply(reapply),
    .cfg_wr_en(wr_en), .cfg_wr_addr(wr_addr), .cfg_wr_data(wr_data),
    .cfg_rd_addr(rd_addr), .cfg_rd_data(rd24),
    .smp_valid(v24), .smp_ready(ready), .smp_data(d24));

  dds_dual_tone #(.PHASE_W(16), .LUT_BITS(LUT)) u_dut_pw16 (
    .clk(clk), .rst_n(rst_n), .gen_enable(gen_enable), .reapply(reapply),
    .cfg_wr_en(wr_en), .cfg_wr_addr(wr_addr), .cfg_wr_data(wr_data),
    .cfg_rd_addr(rd_addr), .cfg_rd_data(rd16),
    .smp_valid(v16), .smp_ready(ready), .smp_data(d16));

  dds_dual_tone #(.PHASE_W(24), .LUT_BITS(LUT), .GEN_EN(1'b0)) u_dut_off (
    .clk(clk), .rst_n(rst_n), .gen_enable(gen_enable), .reapply(reapply),
    .cfg_wr_en(wr_en), .cfg_wr_addr(wr_addr), .cfg_wr_data(wr_data),
    .cfg_rd_addr(rd_addr), .cfg_rd_data(rdoff),
    .smp_valid(voff), .smp_ready(ready), .smp_data(doff));

  task automatic chk(input string req, input longint act, input longint exp, input int tol);
    longint diff;
    n_chk++;
    diff = act - exp;
    if (diff < 0) diff = -diff;
    if (diff > tol) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    case (a)
      3'd0: m_scale[0] = d[15:0];
      3'd1: begin m_init_lo[0] = d[31:16]; m_incr_lo[0] = d[15:0]; end
      3'd2: m_scale[1] = d[15:0];
      3'd3: begin m_init_lo[1] = d[31:16]; m_incr_lo[1] = d[15:0]; end
      3'd4: begin m_init_hi[0] = d[31:16]; m_incr_hi[0] = d[15:0]; end
      3'd5: begin m_init_hi[1] = d[31:16]; m_incr_hi[1] = d[15:0]; end
      default: ;
    endcase
  endtask

  task automatic rd_chk(input logic [2:0] a, input longint e24, input longint e16, input string req);
    @(negedge clk);
    rd_addr = a;
    #1;
    chk({req, " wide"}, longint'(rd24), e24, 0);
    chk({req, " narrow"}, longint'(rd16), e16, 0);
  endtask

  function automatic int sine_ref(input int idx);
    real ang, v;
    ang = 2.0 * 3.14159265358979 * idx / real'(1 << LUT);
    v = 32767.0 * $sin(ang);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  function automatic int expect_smp(input int k, input int pw);
    longint modv, hmask, inc, ini, ph;
    int sum, s, sc, term;
    modv = longint'(1) << pw;
    sum = 0;
    for (int t = 0; t < 2; t++) begin
      hmask = (pw > 16) ? ((longint'(1) << (pw - 16)) - 1) : 0;
      inc = longint'(m_incr_lo[t]) + ((longint'(m_incr_hi[t]) & hmask) << 16);
      ini = longint'(m_init_lo[t]) + ((longint'(m_init_hi[t]) & hmask) << 16);
      ph = (ini + longint'(k) * inc) % modv;
      s = sine_ref(int'(ph >> (pw - LUT)));
      sc = int'($signed(m_scale[t]));
      term = (s * sc) >>> 14;
      sum += term;
    end
    if (sum > 32767) sum = 32767;
    if (sum < -32768) sum = -32768;
    return sum;
  endfunction

  task automatic run_stream(input int cycles, input int pat, input int reload_at, input string req);
    int k24, k16, exp_cnt, pd24, pd16;
    bit st24, st16;
    k24 = 0; k16 = 0; exp_cnt = 0; st24 = 0; st16 = 0; pd24 = 0; pd16 = 0;
    @(negedge clk);
    gen_enable = 1;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      ready = (pat == 0) ? 1'b1 : ((c % 3) != 1);
      reapply = (c == reload_at);
      #1;
      if (c >= 1 && ready) exp_cnt++;
      if (c == reload_at + 1) begin
        chk("R11 reload gap wide", longint'(v24), 0, 0);
        chk("R11 reload gap narrow", longint'(v16), 0, 0);
        k24 = 0; k16 = 0; st24 = 0; st16 = 0;
      end
      if (st24) chk("R10 hold wide", (v24 && int'($signed(d24)) == pd24) ? 1 : 0, 1, 0);
      if (st16) chk("R10 hold narrow", (v16 && int'($signed(d16)) == pd16) ? 1 : 0, 1, 0);
      if (v24 && ready) begin
        chk(req, longint'($signed(d24)), longint'(expect_smp(k24, 24)), 2);
        k24++;
      end
      if (v16 && ready) begin
        chk({req, " R6 narrow"}, longint'($signed(d16)), longint'(expect_smp(k16, 16)), 2);
        k16++;
      end
      st24 = v24 && !ready; pd24 = int'($signed(d24));
      st16 = v16 && !ready; pd16 = int'($signed(d16));
    end
    reapply = 0;
    if (reload_at < 0) begin
      chk("R3 accepted sample count", longint'(k24), longint'(exp_cnt), 0);
      chk("R3 accepted sample count narrow", longint'(k16), longint'(exp_cnt), 0);
    end
    chk("R12 removed valid", longint'(voff), 0, 0);
    chk("R12 removed data", longint'(doff), 0, 0);
    @(negedge clk);
    gen_enable = 0; ready = 1;
    @(negedge clk);
    #1;
    chk("R11 disable drops valid", longint'(v24), 0, 0);
    chk("R11 disable drops valid narrow", longint'(v16), 0, 0);
  endtask

  task automatic t_reset_state();
    #1;
    chk("R1 valid after reset", longint'(v24), 0, 0);
    chk("R1 valid after reset narrow", longint'(v16), 0, 0);
    rd_chk(3'd0, longint'(24) << 16, longint'(16) << 16, "R1 R2 addr0");
    for (int a = 1; a < 6; a++) rd_chk(3'(a), 0, 0, "R1 zero setting");
  endtask

  task automatic t_register_access();
    wr(3'd0, 32'hFFFF_FFFF);
    rd_chk(3'd0, 64'h0018_FFFF, 64'h0010_FFFF, "R2 width read-only");
    wr(3'd4, 32'hABCD_1234);
    rd_chk(3'd4, 64'h00CD_0034, 0, "R5 R6 extension readback");
    wr(3'd1, 32'h1111_2222);
    rd_chk(3'd1, 64'h1111_2222, 64'h1111_2222, "R5 base readback");
    wr(3'd0, 32'h0); wr(3'd1, 32'h0); wr(3'd4, 32'h0);
  endtask

  task automatic t_single_tone();
    wr(3'd0, 32'h0000_4000);
    wr(3'd1, 32'h4000_0000);
    wr(3'd4, 32'h0010_0001);
    run_stream(40, 0, -1, "R4 R5 single tone");
    wr(3'd0, 32'h0000_C000);
    run_stream(12, 0, -1, "R7 negative gain");
  endtask

  task automatic t_two_tones();
    wr(3'd0, 32'h0000_2000);
    wr(3'd2, 32'h0000_E000);
    wr(3'd1, 32'h0000_0300);
    wr(3'd4, 32'h0000_0002);
    wr(3'd3, 32'h8000_1234);
    wr(3'd5, 32'h0000_0005);
    run_stream(40, 0, -1, "R8 two tones");
    run_stream(60, 1, -1, "R10 two tones stalled");
  endtask

  task automatic t_saturation();
    wr(3'd0, 32'h0000_4000);
    wr(3'd2, 32'h0000_4000);
    wr(3'd1, 32'h4000_0000);
    wr(3'd3, 32'h4000_0000);
    wr(3'd4, 32'h0040_0000);
    wr(3'd5, 32'h0040_0000);
    run_stream(6, 0, -1, "R9 clamp positive");
    wr(3'd1, 32'hC000_0000);
    wr(3'd3, 32'hC000_0000);
    wr(3'd4, 32'h00C0_0000);
    wr(3'd5, 32'h00C0_0000);
    run_stream(6, 0, -1, "R9 clamp negative");
  endtask

  task automatic t_reload();
    wr(3'd0, 32'h0000_3000);
    wr(3'd2, 32'h0000_1000);
    wr(3'd1, 32'h2000_0700);
    wr(3'd3, 32'h0000_0900);
    wr(3'd4, 32'h0011_0003);
    wr(3'd5, 32'h0022_0001);
    run_stream(30, 0, 12, "R3 R11 after reload");
  endtask

  initial begin
    for (int t = 0; t < 2; t++) begin
      m_scale[t] = 0; m_incr_lo[t] = 0; m_init_lo[t] = 0; m_incr_hi[t] = 0; m_init_hi[t] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset_state();
    t_register_access();
    t_single_tone();
    t_two_tones();
    t_saturation();
    t_reload();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule